// File: doc/BRIEF.md
# Programmable parallel I/O port

This block gives a host three 8-bit parallel ports (A, B and C) and one control register, all reached through a small 8-bit register bus with a select, a read strobe, a write strobe and a two-bit register address. Each port has its own input pins, output drive values and per-pin output enables, so it can sit directly in front of tri-state pads.

Software configures the block with a single packed configuration word. That word decides, for four groups, whether the pins are inputs or outputs. The four groups are port A, port B, the high nibble of port C and the low nibble of port C. An output group drives the value last written to it. Reading an input group returns the levels on its pins. Only plain latched operation is provided: the mode fields inside the configuration word are accepted, but they change nothing. A synchronous active-low reset turns every pin into an input and clears all output latches.

Top module: `pio_port_unit`

## Requirements
- R1: With `bus_sel` high, the value of `bus_addr` selects a register: 2'b00 is port A, 2'b01 is port B, 2'b10 is port C and 2'b11 is the control register. A read with `bus_sel` and `bus_rd` high at a clock edge loads `bus_rdata` at that edge. `bus_rdata` then holds that value until the next read.
- R2: A control write whose bit 7 is 1 is a configuration command. In that word a direction bit of 1 makes its group an input and 0 makes it an output: bit 4 is port A, bit 3 is port C high nibble, bit 1 is port B, and bit 0 is port C low nibble. Bits 6:5 and bit 2 are mode fields and have no effect.
- R3: After reset every `*_oe` output is 0, every `*_drive` output is 0 and `bus_rdata` is 0.
- R4: For a group set as output, its `*_oe` bits are all 1. From the clock edge that accepts a data write, its `*_drive` bits equal the written value.
- R5: For a group set as input, its `*_oe` bits are 0. A read of that group returns the pin levels present at the read edge.
- R6: The configuration word 8'h90 makes port A an input and makes port B and both nibbles of port C outputs.
- R7: The two nibbles of port C are configured independently. A read of port C returns pins for an input nibble and the latch for an output nibble.
- R8: Every configuration command clears all output latches to 0 at the edge that accepts it.
- R9: A read of the control register returns 8'h00.
- R10: A control write whose bit 7 is 0 changes neither the configuration nor any latch.
- R11: A read of a port configured as output returns its latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_pins_in | input | 8 | Port A pin levels |
| pa_drive | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_pins_in | input | 8 | Port B pin levels |
| pb_drive | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_pins_in | input | 8 | Port C pin levels |
| pc_drive | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
Each bus access is accepted at one rising edge. Read data, drive values and output enables all change at that same edge, so every result is due one cycle after the stimulus is presented. The bench applies each stimulus after a falling edge and compares all outputs against its behavioural model at the following falling edge, which is half a cycle after the accepting edge. Directed checks use the same point to confirm the reset state, mixed nibble reads, the clearing of latches by a configuration command, and the control writes that must be ignored.

// File: rtl/pio_pkg.sv
// Package: shared widths, register addresses and the direction record
// used by the parallel port. Assumes an 8-bit bus and 8-bit ports.
package pio_pkg;
    localparam int PIO_W   = 8;
    localparam int HALF_W  = PIO_W / 2;

    typedef enum logic [1:0] {
        SEL_PORT_A = 2'b00,
        SEL_PORT_B = 2'b01,
        SEL_PORT_C = 2'b10,
        SEL_CTRL   = 2'b11
    } pio_sel_e;

    // One bit per group; 1 means the group is an input.
    typedef struct packed {
        logic a_in;
        logic chi_in;
        logic b_in;
        logic clo_in;
    } pio_dir_t;
endpackage

// File: rtl/pio_cfg_reg.sv
// Configuration register: holds the four group directions. It takes the
// command flag and the four direction bits already extracted from the
// control word; the mode fields never reach it, because they have no effect.
// Assumes the caller qualifies cfg_wr with select, write and the control address.
module pio_cfg_reg
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr,
    input  logic     cmd_flag,
    input  pio_dir_t dir_new,
    output pio_dir_t dir,
    output logic     cfg_clear
);
    // A configuration command is a control write with its flag set.
    assign cfg_clear = cfg_wr & cmd_flag;

    // Purpose: load directions on a command; reset makes all groups inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir <= '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};
        else if (cfg_clear)
            dir <= dir_new;
    end

    // R10
    ignored_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cmd_flag) |=> $stable(dir));

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> (dir == $past(dir_new)));
endmodule

// File: rtl/pio_port_latch.sv
// Output latch for one group of pins. It is written by data writes and
// cleared by configuration commands. Clearing takes priority over writing.
// Assumes the caller decodes the write enable for this group.
module pio_port_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: hold the last written value; clear on reset or a command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R8
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q == '0));

    // R4
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clear) |=> (q == $past(d)));
endmodule

// File: rtl/pio_port_unit.sv
// Top of the parallel port: decodes bus writes, holds the configuration
// and the latches, and registers the read data. Assumes the pin inputs
// are already synchronous to clk.
module pio_port_unit
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [PIO_W-1:0]  bus_wdata,
    output logic [PIO_W-1:0]  bus_rdata,
    input  logic [PIO_W-1:0]  pa_pins_in,
    output logic [PIO_W-1:0]  pa_drive,
    output logic [PIO_W-1:0]  pa_oe,
    input  logic [PIO_W-1:0]  pb_pins_in,
    output logic [PIO_W-1:0]  pb_drive,
    output logic [PIO_W-1:0]  pb_oe,
    input  logic [PIO_W-1:0]  pc_pins_in,
    output logic [PIO_W-1:0]  pc_drive,
    output logic [PIO_W-1:0]  pc_oe
);
    pio_dir_t         dir;
    logic             cfg_clear;
    logic             wr_any;
    logic             rd_any;
    logic [PIO_W-1:0] a_q;
    logic [PIO_W-1:0] b_q;
    logic [PIO_W-1:0] rd_val;
    logic [1:0]       c_in_half;

    assign wr_any = bus_sel & bus_wr;
    assign rd_any = bus_sel & bus_rd;

    pio_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (wr_any && bus_addr == SEL_CTRL),
        .cmd_flag (bus_wdata[7]),
        .dir_new  ('{a_in: bus_wdata[4], chi_in: bus_wdata[3],
                     b_in: bus_wdata[1], clo_in: bus_wdata[0]}),
        .dir      (dir),
        .cfg_clear(cfg_clear)
    );

    pio_port_latch #(.W(PIO_W)) u_lat_a (
        .clk(clk), .rst_n(rst_n), .clear(cfg_clear),
        .we(wr_any && bus_addr == SEL_PORT_A), .d(bus_wdata), .q(a_q)
    );

    pio_port_latch #(.W(PIO_W)) u_lat_b (
        .clk(clk), .rst_n(rst_n), .clear(cfg_clear),
        .we(wr_any && bus_addr == SEL_PORT_B), .d(bus_wdata), .q(b_q)
    );

    // Port C low (h=0) and high (h=1) nibbles follow the same pattern.
    assign c_in_half = {dir.chi_in, dir.clo_in};

    for (genvar h = 0; h < 2; h++) begin : g_chalf
        logic [HALF_W-1:0] c_q;
        pio_port_latch #(.W(HALF_W)) u_lat_c (
            .clk(clk), .rst_n(rst_n), .clear(cfg_clear),
            .we(wr_any && bus_addr == SEL_PORT_C),
            .d(bus_wdata[h*HALF_W +: HALF_W]), .q(c_q)
        );
        assign pc_drive[h*HALF_W +: HALF_W] = c_q;
        assign pc_oe[h*HALF_W +: HALF_W]    = {HALF_W{~c_in_half[h]}};
    end

    assign pa_drive = a_q;
    assign pb_drive = b_q;
    assign pa_oe    = {PIO_W{~dir.a_in}};
    assign pb_oe    = {PIO_W{~dir.b_in}};

    // Purpose: pick the read source; input groups return pins, outputs latches.
    always_comb begin
        unique case (bus_addr)
            SEL_PORT_A: rd_val = dir.a_in ? pa_pins_in : a_q;
            SEL_PORT_B: rd_val = dir.b_in ? pb_pins_in : b_q;
            SEL_PORT_C: begin
                rd_val[PIO_W-1:HALF_W] = dir.chi_in ? pc_pins_in[PIO_W-1:HALF_W]
                                                    : pc_drive[PIO_W-1:HALF_W];
                rd_val[HALF_W-1:0]     = dir.clo_in ? pc_pins_in[HALF_W-1:0]
                                                    : pc_drive[HALF_W-1:0];
            end
            default:    rd_val = '0;
        endcase
    end

    // Purpose: register read data on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_any)
            bus_rdata <= rd_val;
    end

    // R9
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == SEL_CTRL) |=> (bus_rdata == '0));

    // R5
    input_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == SEL_PORT_A && pa_oe == '0)
        |=> (bus_rdata == $past(pa_pins_in)));

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_any && !$past(!rst_n)) |=> $stable(bus_rdata));
endmodule

// File: tb/sim_pio_port_unit.sv
`timescale 1ns/100ps
module sim_pio_port_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_pins_in = 8'h00, pb_pins_in = 8'h00, pc_pins_in = 8'h00;
    logic [7:0] pa_drive, pa_oe, pb_drive, pb_oe, pc_drive, pc_oe;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    // Behavioural reference state
    int m_a, m_b, m_c, m_rd;
    bit m_ain, m_bin, m_hin, m_lin;

    always #2.5 clk = ~clk;

    pio_port_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pa_pins_in(pa_pins_in), .pa_drive(pa_drive), .pa_oe(pa_oe),
        .pb_pins_in(pb_pins_in), .pb_drive(pb_drive), .pb_oe(pb_oe),
        .pc_pins_in(pc_pins_in), .pc_drive(pc_drive), .pc_oe(pc_oe)
    );

    function automatic int port_read(int a);
        int v;
        case (a)
            0: v = m_ain ? int'(pa_pins_in) : m_a;
            1: v = m_bin ? int'(pb_pins_in) : m_b;
            2: v = ((m_hin ? int'(pc_pins_in) : m_c) & 'hF0) |
                   ((m_lin ? int'(pc_pins_in) : m_c) & 'h0F);
            default: v = 0;
        endcase
        return v;
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_c = 0; m_rd = 0;
            m_ain = 1; m_bin = 1; m_hin = 1; m_lin = 1;
        end else begin
            if (bus_sel && bus_rd) m_rd = port_read(int'(bus_addr));
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    2'd0: m_a = bus_wdata;
                    2'd1: m_b = bus_wdata;
                    2'd2: m_c = bus_wdata;
                    default: if (bus_wdata[7]) begin
                        m_ain = bus_wdata[4]; m_hin = bus_wdata[3];
                        m_bin = bus_wdata[1]; m_lin = bus_wdata[0];
                        m_a = 0; m_b = 0; m_c = 0;
                    end
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Compare every output with the model half a cycle after each edge
    always @(negedge clk) begin
        if (started) begin
            chk("R1 rdata", bus_rdata, m_rd);
            chk("R4 pa_drive", pa_drive, m_a);
            chk("R4 pb_drive", pb_drive, m_b);
            chk("R4 pc_drive", pc_drive, m_c);
            chk("R5 pa_oe", pa_oe, m_ain ? 0 : 'hFF);
            chk("R5 pb_oe", pb_oe, m_bin ? 0 : 'hFF);
            chk("R7 pc_oe", pc_oe, (m_hin ? 0 : 'hF0) | (m_lin ? 0 : 'h0F));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R3 pa_oe", pa_oe, 0); chk("R3 pb_oe", pb_oe, 0);
        chk("R3 pc_oe", pc_oe, 0); chk("R3 drive", pa_drive | pb_drive | pc_drive, 0);
        chk("R3 rdata", bus_rdata, 0);

        pa_pins_in = 8'h5A;
        rd(2'd0, v); chk("R5 read A pins", v, 8'h5A);

        wr(2'd3, 8'h90);
        chk("R6 pa_oe", pa_oe, 8'h00); chk("R6 pb_oe", pb_oe, 8'hFF);
        chk("R6 pc_oe", pc_oe, 8'hFF);

        wr(2'd1, 8'h3C); chk("R4 pb_drive", pb_drive, 8'h3C);
        wr(2'd2, 8'hA5); chk("R4 pc_drive", pc_drive, 8'hA5);
        rd(2'd1, v); chk("R11 read B latch", v, 8'h3C);
        pa_pins_in = 8'hC3;
        rd(2'd0, v); chk("R1 read A select", v, 8'hC3);
        rd(2'd2, v); chk("R1 read C select", v, 8'hA5);

        wr(2'd3, 8'h15);
        chk("R10 pb_oe", pb_oe, 8'hFF); chk("R10 pb_drive", pb_drive, 8'h3C);
        chk("R10 pc_drive", pc_drive, 8'hA5); chk("R10 pa_oe", pa_oe, 8'h00);

        rd(2'd3, v); chk("R9 ctrl read", v, 8'h00);

        wr(2'd3, 8'h88);
        chk("R8 pb cleared", pb_drive, 8'h00); chk("R8 pc cleared", pc_drive, 8'h00);
        chk("R7 pc_oe split", pc_oe, 8'h0F);
        wr(2'd2, 8'h7E);
        pc_pins_in = 8'hB2;
        rd(2'd2, v); chk("R7 mixed C read", v, 8'hBE);

        wr(2'd3, 8'hE4);
        chk("R2 modes ignored A", pa_oe, 8'hFF); chk("R2 modes ignored C", pc_oe, 8'hFF);
        wr(2'd0, 8'h11);
        rd(2'd0, v); chk("R11 read A latch", v, 8'h11);
        wr(2'd3, 8'h9B);
        chk("R2 all inputs", pa_oe | pb_oe | pc_oe, 8'h00);
        chk("R8 pa cleared", pa_drive, 8'h00);
        pb_pins_in = 8'h69;
        rd(2'd1, v); chk("R5 read B pins", v, 8'h69);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule